// File: doc/BRIEF.md
# Rotating Register File for Software-Pipelined Loops

This block is a register file whose upper region is renamed on every iteration of a software-pipelined loop. The low registers are a fixed bank addressed directly. Each specifier that lands in the upper bank is offset by a rotation base. The sum wraps inside that bank, so each loop iteration sees a fresh set of physical registers while the code keeps the same specifiers.

The file has two combinational read ports and one write port. All three translate their specifiers with the same base. A one-cycle rotate pulse marks the loop-closing branch and moves the base down by one. The effect is that a value written as register k is found as register k+d after d rotations. A producer with a three-cycle latency can therefore write register 9 and have its consumer read register 12. A clear pulse returns the base to zero, and the current base is visible on an output.

Top module: `rot_regfile`

## Requirements
- R1: Specifiers 0 to 7 select physical registers 0 to 7 directly, whatever the base.
- R2: A specifier s from 8 to 31 selects physical register 8 + ((s - 8 + base) mod 24), on both read ports and on the write port.
- R3: Each cycle with `rot_step` high and `base_clr` low lowers the base by one, and base 0 goes to 23. `base_out` shows the base that is in use in the current cycle.
- R4: `base_clr` high sets the base to 0 on the next cycle and takes priority over `rot_step`.
- R5: A write in the same cycle as a rotate or clear pulse uses the base from before the pulse. The new base applies from the next cycle.
- R6: A value written to rotating specifier k is read back through specifier 8 + ((k - 8 + d) mod 24) after d rotations.
- R7: Reads are combinational. When a read targets the physical register being written in the same cycle, it returns the write data.
- R8: When `rst_n` is low at a clock edge, the base becomes 0 and every register becomes 0.
- R9: The two read ports are independent. Each port returns the register selected by its own specifier in the same cycle.
- R10: With `rot_step` and `base_clr` both low, the base keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rot_step | input | 1 | Loop-closing pulse; lowers the base by one |
| base_clr | input | 1 | Returns the base to zero |
| wr_en | input | 1 | Write enable |
| wr_spec | input | 5 | Logical write specifier |
| wr_data | input | 32 | Write data |
| rd0_spec | input | 5 | Logical specifier, read port 0 |
| rd0_data | output | 32 | Read data, port 0 |
| rd1_spec | input | 5 | Logical specifier, read port 1 |
| rd1_data | output | 32 | Read data, port 1 |
| base_out | output | 5 | Current rotation base |

## Verification
The bench targets five situations where a faulty design would go wrong:
- **Wrap of the base.** The base is rotated through 0 to 23. An unwrapped decrement would jump to 31 and send rotating specifiers outside the bank.
- **Wrap of the sum.** Specifier plus base is driven past the top of the bank. A design that wraps over the whole file would land in the fixed registers and corrupt them.
- **Write during a rotate.** A write is issued in the same cycle as a rotate. Using the new base too early would store the value one register away from where the later read expects it.
- **Same-cycle read and write.** Reads and writes hit the same register in the same cycle. Without forwarding the read would return the stale value.
- **Reset in mid-run.** A reset is applied in the middle of a run. Registers that are not cleared would leak old loop data.

// File: rtl/rrf_pkg.sv
// Shared constants and index arithmetic for the rotating register file.
// Assumes the rotating bank sits directly above the fixed bank.
package rrf_pkg;
    localparam int FIX_REGS_DEF = 8;
    localparam int ROT_REGS_DEF = 24;
    localparam int DATA_W_DEF   = 32;

    // Wrap an offset plus base into [0, n); both inputs lie in [0, n).
    function automatic int wrap_add(input int off, input int base, input int n);
        int s;
        s = off + base;
        if (s >= n) s = s - n;
        return s;
    endfunction
endpackage

// File: rtl/rrf_base_ctr.sv
// Rotation base register. It counts down by one on each rotate pulse and
// wraps from 0 to ROT_REGS-1. A clear pulse forces zero and has priority.
// Assumes ROT_REGS >= 2.
module rrf_base_ctr #(
    parameter int ROT_REGS = 24,
    parameter int BW       = $clog2(ROT_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rot_step,
    input  logic          base_clr,
    output logic [BW-1:0] base
);
    localparam logic [BW-1:0] TOP = BW'(ROT_REGS - 1);

    // Base update: reset or clear, else a wrapped decrement on a rotate.
    always_ff @(posedge clk) begin
        if (!rst_n || base_clr)
            base <= '0;
        else if (rot_step)
            base <= (base == '0) ? TOP : base - 1'b1;
    end

    AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        base <= TOP); // R3
    AST_BASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_step && !base_clr && base == '0) |=> base == TOP); // R3
    AST_BASE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        base_clr |=> base == '0); // R4
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_step && !base_clr) |=> $stable(base)); // R10
endmodule

// File: rtl/rrf_map.sv
// Logical-to-physical translation for one port. Fixed specifiers pass
// through unchanged. Rotating specifiers are offset by the base, modulo
// the size of the rotating bank. Purely combinational; the clock is used
// only by the local checks.
module rrf_map #(
    parameter int FIX_REGS = 8,
    parameter int ROT_REGS = 24,
    parameter int AW       = $clog2(FIX_REGS + ROT_REGS),
    parameter int BW       = $clog2(ROT_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] spec,
    input  logic [BW-1:0] base,
    output logic [AW-1:0] phys
);
    import rrf_pkg::*;

    localparam int NREG = FIX_REGS + ROT_REGS;

    int off;

    // Translation: identity in the fixed bank, wrapped offset above it.
    always_comb begin
        off = int'(spec) - FIX_REGS;
        if (int'(spec) < FIX_REGS)
            phys = spec;
        else
            phys = AW'(FIX_REGS + wrap_add(off, int'(base), ROT_REGS));
    end

    AST_FIX_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(spec) < FIX_REGS) |-> phys == spec); // R1
    AST_ROT_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(spec) >= FIX_REGS) |-> (int'(phys) >= FIX_REGS && int'(phys) < NREG)); // R2
endmodule

// File: rtl/rrf_store.sv
// Register storage with one write port and NRD combinational read ports.
// A read of the register being written in the same cycle returns the
// write data. Synchronous reset clears every entry.
module rrf_store #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    parameter int NRD    = 2,
    parameter int AW     = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_phys,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]      rd_phys,
    output logic [NRD-1:0][DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] mem [NREG];

    // Storage: clear on reset, else store the write data at the physical index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_phys] <= wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        // Read path with forwarding from a same-cycle write.
        always_comb begin
            if (wr_en && wr_phys == rd_phys[g])
                rd_data[g] = wr_data;
            else
                rd_data[g] = mem[rd_phys[g]];
        end
    end

    AST_WR_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_phys)] == $past(wr_data)); // R5
endmodule

// File: rtl/rot_regfile.sv
// Rotating register file top. A shared rotation base feeds three index
// translators (two reads, one write) in front of the storage. A rotate
// pulse takes effect from the next cycle, so a write issued together with
// it still uses the old base.
module rot_regfile #(
    parameter int FIX_REGS = rrf_pkg::FIX_REGS_DEF,
    parameter int ROT_REGS = rrf_pkg::ROT_REGS_DEF,
    parameter int DATA_W   = rrf_pkg::DATA_W_DEF,
    parameter int AW       = $clog2(FIX_REGS + ROT_REGS),
    parameter int BW       = $clog2(ROT_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_step,
    input  logic              base_clr,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_spec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd0_spec,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [AW-1:0]     rd1_spec,
    output logic [DATA_W-1:0] rd1_data,
    output logic [BW-1:0]     base_out
);
    localparam int NREG  = FIX_REGS + ROT_REGS;
    localparam int NPORT = 3;  // index 0,1: reads; index 2: write

    logic [BW-1:0]                base;
    logic [NPORT-1:0][AW-1:0]     lspec;
    logic [NPORT-1:0][AW-1:0]     pidx;
    logic [1:0][AW-1:0]           rd_phys;
    logic [1:0][DATA_W-1:0]       rd_data;

    assign lspec    = {wr_spec, rd1_spec, rd0_spec};
    assign rd_phys  = {pidx[1], pidx[0]};
    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];
    assign base_out = base;

    rrf_base_ctr #(.ROT_REGS(ROT_REGS), .BW(BW)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .rot_step (rot_step),
        .base_clr (base_clr),
        .base     (base)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rrf_map #(.FIX_REGS(FIX_REGS), .ROT_REGS(ROT_REGS), .AW(AW), .BW(BW)) u_map (
            .clk   (clk),
            .rst_n (rst_n),
            .spec  (lspec[p]),
            .base  (base),
            .phys  (pidx[p])
        );
    end

    rrf_store #(.NREG(NREG), .DATA_W(DATA_W), .NRD(2), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_phys (pidx[2]),
        .wr_data (wr_data),
        .rd_phys (rd_phys),
        .rd_data (rd_data)
    );
endmodule

// File: tb/sim_rot_regfile.sv
// Bench: a behavioural reference (array plus integer base) is compared
// with the design on every clock.
module sim_rot_regfile;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        rot_step = 0, base_clr = 0, wr_en = 0;
    logic [4:0]  wr_spec = 0, rd0_spec = 0, rd1_spec = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd0_data, rd1_data;
    logic [4:0]  base_out;

    int total = 0, bad = 0;
    int mbase = 0;
    logic [31:0] mregs [32];
    bit finished = 0;

    always #5 clk = ~clk;

    rot_regfile u0 (
        .clk(clk), .rst_n(rst_n), .rot_step(rot_step), .base_clr(base_clr),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
        .rd0_spec(rd0_spec), .rd0_data(rd0_data),
        .rd1_spec(rd1_spec), .rd1_data(rd1_data), .base_out(base_out)
    );

    function automatic int pmap(int s, int b);
        if (s < 8) return s;
        return 8 + ((s - 8 + b) % 24);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare reads and base, then update the model.
    task automatic cyc(string req, bit we, int ws, logic [31:0] wd,
                       int r0, int r1, bit rot, bit clr);
        int wp;
        int p0;
        int p1;
        wr_en = we; wr_spec = 5'(ws); wr_data = wd;
        rd0_spec = 5'(r0); rd1_spec = 5'(r1); rot_step = rot; base_clr = clr;
        #1;
        wp = pmap(ws, mbase);
        p0 = pmap(r0, mbase);
        p1 = pmap(r1, mbase);
        if (rst_n) begin
            check(req, rd0_data, (we && wp == p0) ? wd : mregs[p0]);
            check(req, rd1_data, (we && wp == p1) ? wd : mregs[p1]);
            check("R3 base", 32'(base_out), 32'(mbase));
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mregs[i] = '0;
            mbase = 0;
        end else begin
            if (we) mregs[wp] = wd;
            if (clr) mbase = 0;
            else if (rot) mbase = (mbase + 23) % 24;
        end
        @(negedge clk);
    endtask

    task automatic idle(string req, int r0, int r1);
        cyc(req, 0, 0, 0, r0, r1, 0, 0);
    endtask

    initial begin
        #(10 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mregs[i] = '0;
        @(negedge clk);
        rst_n = 0;
        cyc("R8", 0, 0, 0, 0, 0, 0, 0);
        cyc("R8", 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1;
        // R8: every register reads zero after reset, base zero
        check("R8 base", 32'(base_out), 0);
        for (int i = 0; i < 32; i += 2) idle("R8 clear", i, i + 1);

        // R1: fixed register unaffected by rotation
        cyc("R1", 1, 3, 32'hA5A5_0003, 3, 4, 0, 0);
        for (int i = 0; i < 5; i++) cyc("R1", 0, 0, 0, 3, 7, 1, 0);
        check("R1 fixed", rd0_data, 32'hA5A5_0003);

        // R6: write spec 9 now, three rotations later read spec 12
        cyc("R4", 0, 0, 0, 0, 0, 0, 1);
        cyc("R6", 1, 9, 32'hCAFE_0009, 9, 9, 1, 0);
        cyc("R6", 0, 0, 0, 10, 9, 1, 0);
        cyc("R6", 0, 0, 0, 11, 9, 1, 0);
        idle("R6", 12, 9);
        check("R6 k+3", rd0_data, 32'hCAFE_0009);

        // R2/R6: sum wraps inside the rotating bank (write 30, read 10 after 4)
        cyc("R4", 0, 0, 0, 0, 0, 0, 1);
        cyc("R2", 1, 30, 32'hBEEF_001E, 30, 8, 0, 0);
        for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 0, 30, 8, 1, 0);
        idle("R2", 10, 0);
        check("R6 wrap", rd0_data, 32'hBEEF_001E);
        check("R1 no spill", rd1_data, 32'h0);

        // R3: full turn of the base, wrap 0 -> 23
        cyc("R4", 0, 0, 0, 0, 0, 0, 1);
        cyc("R3", 0, 0, 0, 8, 31, 1, 0);
        check("R3 wrap", 32'(base_out), 23);
        for (int i = 0; i < 23; i++) cyc("R3", 0, 0, 0, 8, 31, 1, 0);
        check("R3 full turn", 32'(base_out), 0);

        // R10: base holds without pulses
        cyc("R3", 0, 0, 0, 0, 0, 1, 0);
        idle("R10", 0, 0);
        idle("R10", 0, 0);
        check("R10 hold", 32'(base_out), 23);

        // R5: write with rotate uses old base (23): spec 8 -> phys 31
        cyc("R5", 1, 8, 32'h5555_0008, 8, 9, 1, 0);
        idle("R5", 9, 8);
        check("R5 old base", rd0_data, 32'h5555_0008);

        // R4: clear beats rotate
        cyc("R4", 0, 0, 0, 0, 0, 1, 1);
        check("R4 clr", 32'(base_out), 0);

        // R7/R9: same-cycle forwarding on both ports, and distinct ports
        cyc("R7", 1, 15, 32'h7777_000F, 15, 15, 0, 0);
        cyc("R9", 1, 2, 32'h2222_0002, 15, 3, 0, 0);
        check("R9 port1", rd1_data, 32'hA5A5_0003);
        check("R9 port0", rd0_data, 32'h7777_000F);

        // mixed random traffic against the model
        for (int i = 0; i < 600; i++)
            cyc("R2 mix", ($urandom % 3) != 0, $urandom % 32, $urandom,
                $urandom % 32, $urandom % 32, ($urandom % 3) == 0,
                ($urandom % 29) == 0);

        // R8: reset in mid-run clears data and base
        rst_n = 0;
        cyc("R8", 0, 0, 0, 0, 0, 1, 0);
        rst_n = 1;
        check("R8 base mid", 32'(base_out), 0);
        for (int i = 0; i < 32; i += 2) idle("R8 mid", i, i + 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule